// File: doc/BRIEF.md
# GPIO Port Register Block

This block is the register front end of one 16-pin general-purpose IO port. A bus master reaches it through a simple 32-bit request/response interface: a select strobe with a write flag, a byte address, write data, registered read data and a one-cycle ready pulse. The block holds the port's configuration words at fixed word offsets:

| Offset | Contents |
|--------|----------|
| 0x00 | Pin mode |
| 0x04 | Output driver type |
| 0x08 | Slew speed |
| 0x0C | Pull selection |
| 0x10 | Synchronized pin input |
| 0x14 | Output data |
| 0x18 | Atomic set/clear |
| 0x1C | Reserved |
| 0x20 | Function select, pins 0..7 |
| 0x24 | Function select, pins 8..15 |

Each configuration word is driven straight out to the pad ring.

The output data word can be changed in two ways. It can be written directly, so software may read-modify-write it. It can also be changed through the write-only set/clear word, which alters chosen bits in one bus write with no read first. An interrupt handler that runs between a read and a write of some other code therefore cannot lose its update. Pin inputs pass through a two-flop synchronizer, and the input word shows the synchronized value; that word cannot be written.

A two-state bus controller sequences every access. In state `ST_IDLE` it waits for `bus_sel`. Transition IDLE->RESP is taken at the edge where `bus_sel` is seen; on that edge a write commits or read data is captured. In state `ST_RESP` it asserts `bus_ready` for one cycle. Transition RESP->IDLE is unconditional. The master must drop `bus_sel` after seeing `bus_ready`.

Top module: `gpio_port_regs`

## Requirements
- R1: After reset every configuration word and the output data word are zero, so all pins are in input mode with `pin_out` low, `pin_oe` low and `bus_ready` low.
- R2: An access seen in IDLE is answered by `bus_ready` high in exactly the next cycle, for one cycle only. `bus_rdata` holds the read result while `bus_ready` is high.
- R3: Mode (0x00), output type (0x04, bits 15:0 only, upper bits read 0), speed (0x08), pull (0x0C), function-select low (0x20) and high (0x24) are read/write. Each drives its `cfg_*` output, with function-select low on `cfg_af[31:0]` and high on `cfg_af[63:32]`. A write is visible at the outputs in the cycle `bus_ready` is high.
- R4: The input word (0x10) is read-only: a bus write to it changes no register or output, and reads still return the pin value.
- R5: The output data word (0x14) is read/write in bits 15:0, reads 0 in bits 31:16, drives `pin_out`, and supports read-modify-write.
- R6: A write to the set/clear word (0x18) with bit n (0..15) at 1 drives `pin_out[n]` high. Bit n+16 at 1 drives `pin_out[n]` low. Every pin whose two bits are both 0 keeps its value.
- R7: If a set/clear write has both bit n and bit n+16 at 1, pin n is set.
- R8: The set/clear word and the reserved word (0x1C) read as 0. Writes to 0x1C and to unmapped offsets (0x28..0x3C) change nothing and those offsets read 0.
- R9: Pin n's mode is field bits 2n+1:2n (00 input, 01 output, 10 alternate, 11 analog). `pin_oe[n]` is high exactly when that field is 01, so writing 0x400 to the mode word enables only pin 5.
- R10: A pin change set up before clock edge k is returned by reads accepted at edge k+2 or later. A read accepted at edge k+1 still returns the old value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Access request, held until `bus_ready` |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 6 | Byte address; bits 1:0 ignored |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid while `bus_ready` |
| bus_ready | output | 1 | One-cycle access completion |
| pin_in | input | 16 | Raw pin levels |
| pin_out | output | 16 | Output data word |
| pin_oe | output | 16 | Pin in general output mode |
| cfg_mode | output | 32 | Mode word |
| cfg_otype | output | 16 | Output type per pin |
| cfg_speed | output | 32 | Speed word |
| cfg_pull | output | 32 | Pull word |
| cfg_af | output | 64 | Function-select words, high:low |

## Verification
Every access commits at the edge it is accepted, so written values reach `pin_out`, `pin_oe` and `cfg_*` one edge later, and read data and `bus_ready` appear together in that same cycle. The bench drives a request on a falling edge and samples all results on the following falling edge. Pin inputs take two more edges to reach the input word, so the R10 check launches one read one edge after a pin change, where it expects the old value, and a second read later, where it expects the new value.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RESP = 1'b1
    } bus_state_e;

    // word indices (byte offset >> 2)
    localparam logic [3:0] WI_MODE  = 4'd0;
    localparam logic [3:0] WI_OTYPE = 4'd1;
    localparam logic [3:0] WI_SPEED = 4'd2;
    localparam logic [3:0] WI_PULL  = 4'd3;
    localparam logic [3:0] WI_IN    = 4'd4;
    localparam logic [3:0] WI_OUT   = 4'd5;
    localparam logic [3:0] WI_SETCL = 4'd6;
    localparam logic [3:0] WI_RSVD  = 4'd7;
    localparam logic [3:0] WI_AFLO  = 4'd8;
    localparam logic [3:0] WI_AFHI  = 4'd9;

    localparam logic [1:0] PMODE_IN  = 2'b00;
    localparam logic [1:0] PMODE_OUT = 2'b01;

endpackage

// File: rtl/gpio_bus_fsm.sv
module gpio_bus_fsm
    import gpio_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic sel,
    input  logic wr,
    output logic wr_stb,
    output logic rd_stb,
    output logic ready
);

    bus_state_e state_q, state_d;
    logic       accept;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        accept  = 1'b0;
        ready   = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (sel) begin
                    accept  = 1'b1;
                    state_d = ST_RESP;
                end
            end
            ST_RESP: begin
                ready   = 1'b1;
                state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    assign wr_stb = accept & wr;
    assign rd_stb = accept & ~wr;

    AST_READY_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        ready |=> !ready); // R2
    AST_READY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (!ready && sel) |=> ready); // R2

endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
    parameter int WIDTH  = 16,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] raw,
    output logic [WIDTH-1:0] synced
);

    logic [WIDTH-1:0] stage_q [STAGES];

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q[i] <= '0;
                else        stage_q[i] <= raw;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q[i] <= '0;
                else        stage_q[i] <= stage_q[i-1];
            end
        end
    end

    assign synced = stage_q[STAGES-1];

endmodule

// File: rtl/gpio_regfile.sv
module gpio_regfile
    import gpio_pkg::*;
#(
    parameter int PINS   = 16,
    parameter int DATA_W = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_stb,
    input  logic                rd_stb,
    input  logic [3:0]          word_idx,
    input  logic [DATA_W-1:0]   wdata,
    input  logic [PINS-1:0]     in_word,
    output logic [DATA_W-1:0]   rdata,
    output logic [PINS-1:0]     out_q,
    output logic [2*PINS-1:0]   mode_q,
    output logic [PINS-1:0]     otype_q,
    output logic [2*PINS-1:0]   speed_q,
    output logic [2*PINS-1:0]   pull_q,
    output logic [2*DATA_W-1:0] af_q
);

    localparam int CLR_LSB = DATA_W / 2;

    logic [DATA_W-1:0] af_lo_q, af_hi_q;
    logic [DATA_W-1:0] rd_val;
    logic [PINS-1:0]   set_bits, clr_bits;

    assign set_bits = wdata[PINS-1:0];
    assign clr_bits = wdata[CLR_LSB +: PINS];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q  <= '0;
            otype_q <= '0;
            speed_q <= '0;
            pull_q  <= '0;
            out_q   <= '0;
            af_lo_q <= '0;
            af_hi_q <= '0;
        end else if (wr_stb) begin
            unique case (word_idx)
                WI_MODE:  mode_q  <= wdata[2*PINS-1:0];
                WI_OTYPE: otype_q <= wdata[PINS-1:0];
                WI_SPEED: speed_q <= wdata[2*PINS-1:0];
                WI_PULL:  pull_q  <= wdata[2*PINS-1:0];
                WI_OUT:   out_q   <= wdata[PINS-1:0];
                WI_SETCL: out_q   <= (out_q & ~clr_bits) | set_bits;
                WI_AFLO:  af_lo_q <= wdata;
                WI_AFHI:  af_hi_q <= wdata;
                default:  ;
            endcase
        end
    end

    always_comb begin
        rd_val = '0;
        unique case (word_idx)
            WI_MODE:  rd_val = DATA_W'(mode_q);
            WI_OTYPE: rd_val = DATA_W'(otype_q);
            WI_SPEED: rd_val = DATA_W'(speed_q);
            WI_PULL:  rd_val = DATA_W'(pull_q);
            WI_IN:    rd_val = DATA_W'(in_word);
            WI_OUT:   rd_val = DATA_W'(out_q);
            WI_AFLO:  rd_val = af_lo_q;
            WI_AFHI:  rd_val = af_hi_q;
            default:  rd_val = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      rdata <= '0;
        else if (rd_stb) rdata <= rd_val;
    end

    assign af_q = {af_hi_q, af_lo_q};

    AST_SETCL_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && word_idx == WI_SETCL) |=>
            ((out_q & $past(set_bits)) == $past(set_bits))); // R7
    AST_SETCL_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && word_idx == WI_SETCL) |=>
            ((out_q & ($past(clr_bits) & ~$past(set_bits))) == '0)); // R6
    AST_SETCL_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && word_idx == WI_SETCL) |=>
            (((out_q ^ $past(out_q)) & ~($past(set_bits) | $past(clr_bits))) == '0)); // R6
    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_stb || (word_idx != WI_OUT && word_idx != WI_SETCL)) |=> $stable(out_q)); // R5
    AST_CFG_HOLD_IN: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && word_idx >= WI_IN && word_idx != WI_OUT && word_idx != WI_SETCL
         && word_idx != WI_AFLO && word_idx != WI_AFHI) |=>
            ($stable(mode_q) && $stable(pull_q) && $stable(af_q))); // R4

endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
    import gpio_pkg::*;
#(
    parameter int PINS        = 16,
    parameter int DATA_W      = 32,
    parameter int ADDR_W      = 6,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_sel,
    input  logic                bus_wr,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [DATA_W-1:0]   bus_wdata,
    output logic [DATA_W-1:0]   bus_rdata,
    output logic                bus_ready,
    input  logic [PINS-1:0]     pin_in,
    output logic [PINS-1:0]     pin_out,
    output logic [PINS-1:0]     pin_oe,
    output logic [2*PINS-1:0]   cfg_mode,
    output logic [PINS-1:0]     cfg_otype,
    output logic [2*PINS-1:0]   cfg_speed,
    output logic [2*PINS-1:0]   cfg_pull,
    output logic [2*DATA_W-1:0] cfg_af
);

    logic            wr_stb, rd_stb;
    logic [3:0]      word_idx;
    logic [PINS-1:0] in_word;

    assign word_idx = bus_addr[5:2];

    gpio_bus_fsm u_fsm (
        .clk    (clk),
        .rst_n  (rst_n),
        .sel    (bus_sel),
        .wr     (bus_wr),
        .wr_stb (wr_stb),
        .rd_stb (rd_stb),
        .ready  (bus_ready)
    );

    gpio_in_sync #(.WIDTH(PINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .raw    (pin_in),
        .synced (in_word)
    );

    gpio_regfile #(.PINS(PINS), .DATA_W(DATA_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_stb   (wr_stb),
        .rd_stb   (rd_stb),
        .word_idx (word_idx),
        .wdata    (bus_wdata),
        .in_word  (in_word),
        .rdata    (bus_rdata),
        .out_q    (pin_out),
        .mode_q   (cfg_mode),
        .otype_q  (cfg_otype),
        .speed_q  (cfg_speed),
        .pull_q   (cfg_pull),
        .af_q     (cfg_af)
    );

    for (genvar p = 0; p < PINS; p++) begin : g_oe
        assign pin_oe[p] = (cfg_mode[2*p +: 2] == PMODE_OUT);
    end

    AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (pin_out == '0 && cfg_mode == '0)); // R1
    AST_OE_FOLLOWS_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_mode == '0) |-> (pin_oe == '0)); // R9

endmodule

// File: tb/gpio_port_regs_tb.sv
module gpio_port_regs_tb_top;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_ready;
    logic [15:0] pin_in = '0;
    logic [15:0] pin_out, pin_oe, cfg_otype;
    logic [31:0] cfg_mode, cfg_speed, cfg_pull;
    logic [63:0] cfg_af;

    int n_checks = 0;
    int n_fail   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    gpio_port_regs dut_i (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_ready(bus_ready), .pin_in(pin_in), .pin_out(pin_out),
        .pin_oe(pin_oe), .cfg_mode(cfg_mode), .cfg_otype(cfg_otype),
        .cfg_speed(cfg_speed), .cfg_pull(cfg_pull), .cfg_af(cfg_af)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // starts and ends on a falling edge; results sampled in the ready cycle
    task automatic bus_write(input logic [5:0] a, input logic [31:0] d);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); @(negedge clk);
        check("R2 write ready", 64'(bus_ready), 64'd1);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [5:0] a, output logic [31:0] d);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        @(posedge clk); @(negedge clk);
        check("R2 read ready", 64'(bus_ready), 64'd1);
        d = bus_rdata;
        bus_sel = 1'b0;
        @(posedge clk); @(negedge clk);
    endtask

    task automatic finish_write();
        @(posedge clk); @(negedge clk);
    endtask

    task automatic t_reset();
        logic [31:0] d;
        check("R1 ready", 64'(bus_ready), 64'd0);
        check("R1 pin_out", 64'(pin_out), 64'd0);
        check("R1 pin_oe", 64'(pin_oe), 64'd0);
        check("R1 cfg", {cfg_mode, cfg_speed}, 64'd0);
        check("R1 af", cfg_af, 64'd0);
        for (int i = 0; i < 10; i++) begin
            if (i != 4) begin
                bus_read(6'(i*4), d);
                check("R1 read zero", 64'(d), 64'd0);
            end
        end
    endtask

    task automatic t_handshake();
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = 6'h00;
        check("R2 idle before", 64'(bus_ready), 64'd0);
        @(posedge clk); @(negedge clk);
        check("R2 ready next cycle", 64'(bus_ready), 64'd1);
        bus_sel = 1'b0;
        @(posedge clk); @(negedge clk);
        check("R2 ready one cycle", 64'(bus_ready), 64'd0);
    endtask

    task automatic t_config();
        logic [31:0] d;
        bus_write(6'h00, 32'hA5A5_0F0F);
        check("R3 mode out", 64'(cfg_mode), 64'hA5A5_0F0F);
        finish_write();
        bus_write(6'h04, 32'hFFFF_FFFF);
        check("R3 otype out", 64'(cfg_otype), 64'hFFFF);
        finish_write();
        bus_read(6'h04, d);
        check("R3 otype upper zero", 64'(d), 64'h0000_FFFF);
        bus_write(6'h08, 32'h1234_5678); finish_write();
        bus_write(6'h0C, 32'h9ABC_DEF0); finish_write();
        bus_write(6'h20, 32'h7654_3210); finish_write();
        bus_write(6'h24, 32'hFEDC_BA98); finish_write();
        check("R3 speed out", 64'(cfg_speed), 64'h1234_5678);
        check("R3 pull out", 64'(cfg_pull), 64'h9ABC_DEF0);
        check("R3 af out", cfg_af, 64'hFEDC_BA98_7654_3210);
        bus_read(6'h00, d); check("R3 mode read", 64'(d), 64'hA5A5_0F0F);
        bus_read(6'h0A, d); check("R3 speed read (low addr bits ignored)", 64'(d), 64'h1234_5678);
        bus_read(6'h24, d); check("R3 af high read", 64'(d), 64'hFEDC_BA98);
    endtask

    task automatic t_mode_pin5();
        bus_write(6'h00, 32'h0000_0400);
        check("R9 pin5 oe", 64'(pin_oe), 64'h0020);
        finish_write();
        bus_write(6'h00, 32'h0000_0E01);
        check("R9 mixed modes", 64'(pin_oe), 64'h0001);
        finish_write();
        bus_write(6'h00, 32'h5555_5555);
        check("R9 all out", 64'(pin_oe), 64'hFFFF);
        finish_write();
    endtask

    task automatic t_input();
        logic [31:0] d;
        logic [31:0] mode_before;
        mode_before = cfg_mode;
        pin_in = 16'hA5C3;
        @(posedge clk); @(negedge clk);
        bus_read(6'h10, d);
        check("R10 read at k+1 old", 64'(d), 64'h0);
        bus_read(6'h10, d);
        check("R10 read later new", 64'(d), 64'hA5C3);
        bus_write(6'h10, 32'h0000_FFFF);
        check("R4 write no out effect", 64'(pin_out), 64'h0);
        check("R4 write no mode effect", 64'(cfg_mode), 64'(mode_before));
        finish_write();
        bus_read(6'h10, d);
        check("R4 still pins", 64'(d), 64'hA5C3);
    endtask

    task automatic t_output();
        logic [31:0] d;
        bus_write(6'h14, 32'h1234_5678);
        check("R5 pin_out", 64'(pin_out), 64'h5678);
        finish_write();
        bus_read(6'h14, d);
        check("R5 upper zero", 64'(d), 64'h0000_5678);
        bus_write(6'h14, d | 32'h0000_8000); finish_write();
        bus_read(6'h14, d);
        bus_write(6'h14, d & ~32'h0000_0008); finish_write();
        bus_read(6'h14, d);
        bus_write(6'h14, d ^ 32'h0000_0001); finish_write();
        check("R5 rmw result", 64'(pin_out), 64'hD671);
    endtask

    task automatic t_setclr();
        bus_write(6'h14, 32'h0000_00F0); finish_write();
        bus_write(6'h18, 32'h0000_0101);
        check("R6 set bits 0,8", 64'(pin_out), 64'h01F1);
        finish_write();
        bus_write(6'h18, 32'h0020_0000);
        check("R6 clear pin5 via bit21", 64'(pin_out), 64'h01D1);
        finish_write();
        bus_write(6'h18, 32'h0000_0000);
        check("R6 empty write keeps", 64'(pin_out), 64'h01D1);
        finish_write();
        bus_write(6'h18, 32'h0008_0008);
        check("R7 set wins pin3", 64'(pin_out), 64'h01D9);
        finish_write();
        bus_write(6'h18, 32'h0011_0010);
        check("R7 set wins pin4, clear pin0", 64'(pin_out), 64'h01D8);
        finish_write();
    endtask

    task automatic t_zero_reads();
        logic [31:0] d;
        bus_read(6'h18, d);
        check("R8 setclr reads zero", 64'(d), 64'h0);
        bus_write(6'h1C, 32'hFFFF_FFFF); finish_write();
        bus_read(6'h1C, d);
        check("R8 reserved reads zero", 64'(d), 64'h0);
        bus_write(6'h28, 32'hFFFF_FFFF); finish_write();
        bus_write(6'h3C, 32'hFFFF_FFFF); finish_write();
        bus_read(6'h28, d);
        check("R8 unmapped reads zero", 64'(d), 64'h0);
        bus_read(6'h14, d);
        check("R8 out unchanged", 64'(d), 64'h01D8);
        check("R8 af unchanged", cfg_af, 64'hFEDC_BA98_7654_3210);
        check("R8 otype unchanged", 64'(cfg_otype), 64'hFFFF);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_handshake();
        t_config();
        t_mode_pin5();
        t_input();
        t_output();
        t_setclr();
        t_zero_reads();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule